// File: doc/BRIEF.md
# Floating-Point Magnitude Comparator with Condition-Code Register

This block compares the magnitudes of two floating-point operands and records the boolean outcome in an 8-bit condition-code register. The operand signs are dropped and the compare is exact, so it can never overflow or underflow. Three operand layouts are supported. Single precision uses bits 31:0 of each operand. Double precision uses all 64 bits. The paired mode holds two single-precision values per operand, bits 31:0 as the lower half and bits 63:32 as the upper half, and compares the halves independently.

A 4-bit condition field picks which outcomes count as true. Bit 2 selects "less" (|A| < |B|), bit 1 selects "equal" and bit 0 selects "unordered". Bit 3 makes quiet NaNs signal an invalid operation. A NaN has an all-ones exponent and a nonzero mantissa. It is quiet when the top mantissa bit is set and signalling when that bit is clear. An operation is presented for one cycle on `opValid`. The selected condition code and the two flags change on the following rising edge.

Top module: `fp_abs_compare`

## Requirements
- R1: While `rst_n` is low, and after reset until the first accepted operation, `ccReg`, `invalidFlag` and `oddIdxErr` are all 0.
- R2: For single precision (`fmtSel`=0), one cycle after `opValid`, bit `ccIdx` of `ccReg` becomes (cond[2] AND |A|<|B|) OR (cond[1] AND |A|=|B|) OR (cond[0] AND unordered), with 1 for true. The other seven bits are unchanged.
- R3: Double precision (`fmtSel`=1) follows the same rule as R2 on the full 64-bit operands.
- R4: If either operand is a NaN, less and equal are false and unordered is true. Infinities are ordered and larger than every finite magnitude.
- R5: `invalidFlag` is 1 for the cycle after an operation where either operand is a signalling NaN, or cond[3] is set and either operand is a quiet NaN. Otherwise it is 0 in that cycle.
- R6: In paired mode (`fmtSel`=2) with an even `ccIdx`, the lower-half result goes to bit `ccIdx` and the upper-half result goes to bit `ccIdx`+1. No other bit changes.
- R7: In paired mode, `invalidFlag` is the OR of the invalid conditions of the two halves.
- R8: In paired mode with an odd `ccIdx`, `oddIdxErr` is 1 for one cycle and `ccReg` is not written. `oddIdxErr` is 0 after any other operation.
- R9: When `trapEn` is 1 and the operation raises invalid, `ccReg` is left unchanged while `invalidFlag` is still reported.
- R10: In a cycle without `opValid`, and for the reserved format `fmtSel`=3, `ccReg` is unchanged and both flags are 0 on the next cycle.
- R11: +0 and -0 (and all sign combinations of equal magnitudes) compare equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Operation strobe, one cycle per compare |
| opA | input | 64 | First operand |
| opB | input | 64 | Second operand |
| fmtSel | input | 2 | 0 single, 1 double, 2 paired, 3 reserved |
| condSel | input | 4 | [3] signal on quiet NaN, [2] less, [1] equal, [0] unordered |
| ccIdx | input | 3 | Condition-code index to write |
| trapEn | input | 1 | Suppress the write when invalid is raised |
| ccReg | output | 8 | Condition-code register |
| invalidFlag | output | 1 | Invalid operation raised by the previous operation |
| oddIdxErr | output | 1 | Previous paired operation used an odd index |

## Verification
On every cycle the assertions check the write scope of the register. An idle or reserved cycle leaves it untouched. A scalar operation alters at most one bit, and a paired operation alters only its two target bits. They also check that an odd paired index blocks the write and raises its flag, and that a trapped invalid leaves the register unchanged. Whether the written bit has the right value can only be shown by the bench. It sweeps all pairs of a set of magnitude-ranked values (signed zeros, a denormal, finite values, the largest finite value, both infinities and both NaN kinds) across condition fields, formats and indices. Its expected codes and flags come from the rank order.

// File: rtl/fpac_pkg.sv
package fpac_pkg;
  typedef enum logic [1:0] {
    FMT_SINGLE = 2'd0,
    FMT_DOUBLE = 2'd1,
    FMT_PAIRED = 2'd2,
    FMT_RSVD   = 2'd3
  } fmt_e;

  localparam int SGL_EXP = 8;
  localparam int SGL_MAN = 23;
  localparam int SGL_W   = 1 + SGL_EXP + SGL_MAN;
  localparam int DBL_EXP = 11;
  localparam int DBL_MAN = 52;
  localparam int DBL_W   = 1 + DBL_EXP + DBL_MAN;
  localparam int LANES   = DBL_W / SGL_W;

  typedef struct packed {
    logic       wrLo;
    logic       wrHi;
    logic [2:0] idxLo;
    logic [2:0] idxHi;
    logic       setInv;
    logic       setOdd;
  } strobes_t;
endpackage

// File: rtl/fpac_lane.sv
module fpac_lane #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [3:0]   cond,
  output logic         hit,
  output logic         inv
);
  logic [W-2:0] magA, magB;
  logic nanA, nanB, quietA, quietB, sigA, sigB;
  logic unord, less, equal;

  assign magA   = a[W-2:0];
  assign magB   = b[W-2:0];
  assign nanA   = (&a[W-2:MAN_W]) && (|a[MAN_W-1:0]);
  assign nanB   = (&b[W-2:MAN_W]) && (|b[MAN_W-1:0]);
  assign quietA = nanA && a[MAN_W-1];
  assign quietB = nanB && b[MAN_W-1];
  assign sigA   = nanA && !a[MAN_W-1];
  assign sigB   = nanB && !b[MAN_W-1];

  always_comb begin
    unord = nanA || nanB;
    less  = !unord && (magA < magB);
    equal = !unord && (magA == magB);
    hit   = (cond[2] && less) || (cond[1] && equal) || (cond[0] && unord);
    inv   = sigA || sigB || (cond[3] && (quietA || quietB));
  end
endmodule

// File: rtl/fpac_dp.sv
module fpac_dp
  import fpac_pkg::*;
(
  input  logic [DBL_W-1:0] opA,
  input  logic [DBL_W-1:0] opB,
  input  logic [3:0]       cond,
  input  fmt_e             fmt,
  output logic             resLo,
  output logic             resHi,
  output logic             invAny
);
  logic [LANES-1:0] sglHit, sglInv;
  logic dblHit, dblInv;

  for (genvar g = 0; g < LANES; g++) begin : g_sgl
    fpac_lane #(.EXP_W(SGL_EXP), .MAN_W(SGL_MAN)) u_lane (
      .a(opA[g*SGL_W +: SGL_W]),
      .b(opB[g*SGL_W +: SGL_W]),
      .cond(cond),
      .hit(sglHit[g]),
      .inv(sglInv[g])
    );
  end

  fpac_lane #(.EXP_W(DBL_EXP), .MAN_W(DBL_MAN)) u_dbl (
    .a(opA), .b(opB), .cond(cond), .hit(dblHit), .inv(dblInv)
  );

  always_comb begin
    resHi = sglHit[1];
    unique case (fmt)
      FMT_DOUBLE: begin resLo = dblHit;    invAny = dblInv;     end
      FMT_PAIRED: begin resLo = sglHit[0]; invAny = |sglInv;    end
      default:    begin resLo = sglHit[0]; invAny = sglInv[0];  end
    endcase
  end
endmodule

// File: rtl/fpac_ctrl.sv
module fpac_ctrl
  import fpac_pkg::*;
(
  input  logic     opValid,
  input  fmt_e     fmt,
  input  logic [2:0] ccIdx,
  input  logic     trapEn,
  input  logic     invAny,
  output strobes_t st
);
  logic legal, oddPair, blocked;

  always_comb begin
    legal   = opValid && (fmt != FMT_RSVD);
    oddPair = opValid && (fmt == FMT_PAIRED) && ccIdx[0];
    blocked = trapEn && invAny;
    st.wrLo   = legal && !oddPair && !blocked;
    st.wrHi   = st.wrLo && (fmt == FMT_PAIRED);
    st.idxLo  = ccIdx;
    st.idxHi  = ccIdx | 3'd1;
    st.setInv = legal && invAny;
    st.setOdd = oddPair;
  end
endmodule

// File: rtl/fp_abs_compare.sv
module fp_abs_compare
  import fpac_pkg::*;
#(
  parameter int CC_N = 8,
  localparam int IDX_W = $clog2(CC_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              opValid,
  input  logic [63:0]       opA,
  input  logic [63:0]       opB,
  input  logic [1:0]        fmtSel,
  input  logic [3:0]        condSel,
  input  logic [IDX_W-1:0]  ccIdx,
  input  logic              trapEn,
  output logic [CC_N-1:0]   ccReg,
  output logic              invalidFlag,
  output logic              oddIdxErr
);
  fmt_e     fmt;
  strobes_t st;
  logic     resLo, resHi, invAny;
  logic [CC_N-1:0] ccNext;

  assign fmt = fmt_e'(fmtSel);

  fpac_dp u_dp (
    .opA(opA), .opB(opB), .cond(condSel), .fmt(fmt),
    .resLo(resLo), .resHi(resHi), .invAny(invAny)
  );

  fpac_ctrl u_ctrl (
    .opValid(opValid), .fmt(fmt), .ccIdx(ccIdx), .trapEn(trapEn),
    .invAny(invAny), .st(st)
  );

  always_comb begin
    ccNext = ccReg;
    if (st.wrLo) ccNext[st.idxLo] = resLo;
    if (st.wrHi) ccNext[st.idxHi] = resHi;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ccReg       <= '0;
      invalidFlag <= 1'b0;
      oddIdxErr   <= 1'b0;
    end else begin
      ccReg       <= ccNext;
      invalidFlag <= st.setInv;
      oddIdxErr   <= st.setOdd;
    end
  end
endmodule

// File: rtl/fp_abs_compare_chk.sv
module fp_abs_compare_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       opValid,
  input logic [1:0] fmtSel,
  input logic [2:0] ccIdx,
  input logic       trapEn,
  input logic [7:0] ccReg,
  input logic       invalidFlag,
  input logic       oddIdxErr
);
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!opValid || fmtSel == 2'd3) |=> $stable(ccReg)); // R10
  AST_IDLE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (!opValid || fmtSel == 2'd3) |=> (!invalidFlag && !oddIdxErr)); // R10
  AST_ODD_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (opValid && fmtSel == 2'd2 && ccIdx[0]) |=> ($stable(ccReg) && oddIdxErr)); // R8
  AST_ODD_ONLY_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
    (opValid && (fmtSel != 2'd2 || !ccIdx[0])) |=> !oddIdxErr); // R8
  AST_TRAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (opValid && trapEn) |=> (!invalidFlag || $stable(ccReg))); // R9
  AST_SCALAR_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (opValid && fmtSel[1] == 1'b0) |=> ($countones(ccReg ^ $past(ccReg)) <= 1)); // R2
  AST_PAIR_SCOPE: assert property (@(posedge clk) disable iff (!rst_n)
    (opValid && fmtSel == 2'd2 && !ccIdx[0])
      |=> (((ccReg ^ $past(ccReg)) & ~(8'b11 << $past(ccIdx))) == 8'd0)); // R6
endmodule

bind fp_abs_compare fp_abs_compare_chk u_chk (
  .clk(clk), .rst_n(rst_n), .opValid(opValid), .fmtSel(fmtSel),
  .ccIdx(ccIdx), .trapEn(trapEn), .ccReg(ccReg),
  .invalidFlag(invalidFlag), .oddIdxErr(oddIdxErr)
);

// File: tb/fp_abs_compare_bench.sv
`timescale 1ns/1ps
module fp_abs_compare_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        opValid = 1'b0;
  logic [63:0] opA = '0, opB = '0;
  logic [1:0]  fmtSel = '0;
  logic [3:0]  condSel = '0;
  logic [2:0]  ccIdx = '0;
  logic        trapEn = 1'b0;
  logic [7:0]  ccReg;
  logic        invalidFlag, oddIdxErr;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [7:0] ccExp = '0;

  logic [31:0] sVal [12];
  logic [63:0] dVal [12];
  int rank [12];
  int kind [12]; // 0 number, 1 quiet NaN, 2 signalling NaN

  always #2 clk = ~clk;

  fp_abs_compare u_fp_abs_compare (
    .clk(clk), .rst_n(rst_n), .opValid(opValid), .opA(opA), .opB(opB),
    .fmtSel(fmtSel), .condSel(condSel), .ccIdx(ccIdx), .trapEn(trapEn),
    .ccReg(ccReg), .invalidFlag(invalidFlag), .oddIdxErr(oddIdxErr)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // {invalid, result} from rank order and NaN kinds
  function automatic logic [1:0] model(input int a, input int b, input logic [3:0] c);
    bit nan, lt, eq, inv;
    nan = (kind[a] != 0) || (kind[b] != 0);
    lt  = !nan && (rank[a] < rank[b]);
    eq  = !nan && (rank[a] == rank[b]);
    inv = (kind[a] == 2) || (kind[b] == 2) || (c[3] && (kind[a] == 1 || kind[b] == 1));
    return {inv, (c[2] && lt) || (c[1] && eq) || (c[0] && nan)};
  endfunction

  task automatic issue(input logic [63:0] a, input logic [63:0] b, input logic [1:0] f,
                       input logic [3:0] c, input logic [2:0] cc, input logic t);
    @(negedge clk);
    opA = a; opB = b; fmtSel = f; condSel = c; ccIdx = cc; trapEn = t; opValid = 1'b1;
    @(negedge clk);
    opValid = 1'b0;
  endtask

  task automatic doScalar(input bit dbl, input int ia, input int ib, input logic [3:0] c,
                          input logic [2:0] cc, input logic t);
    logic [1:0] m;
    string tg;
    m = model(ia, ib, c);
    if (dbl) issue(dVal[ia], dVal[ib], 2'd1, c, cc, t);
    else     issue({32'h0, sVal[ia]}, {32'h0, sVal[ib]}, 2'd0, c, cc, t);
    if (!(t && m[1])) ccExp[cc] = m[0];
    if (t) tg = "R9";
    else if (kind[ia] != 0 || kind[ib] != 0) tg = "R4";
    else if (rank[ia] == 0 && rank[ib] == 0) tg = "R11";
    else if (dbl) tg = "R3";
    else tg = "R2";
    chk(tg, ccReg, ccExp);
    chk("R5", invalidFlag, m[1]);
    chk("R8", oddIdxErr, 1'b0);
  endtask

  task automatic doPaired(input int ah, input int al, input int bh, input int bl,
                          input logic [3:0] c, input logic [2:0] cc);
    logic [1:0] mLo, mHi;
    mLo = model(al, bl, c);
    mHi = model(ah, bh, c);
    issue({sVal[ah], sVal[al]}, {sVal[bh], sVal[bl]}, 2'd2, c, cc, 1'b0);
    if (cc[0] == 1'b0) begin
      ccExp[cc] = mLo[0];
      ccExp[cc | 3'd1] = mHi[0];
      chk("R6", ccReg, ccExp);
    end else begin
      chk("R8", ccReg, ccExp);
    end
    chk("R7", invalidFlag, mLo[1] | mHi[1]);
    chk("R8", oddIdxErr, cc[0]);
  endtask

  initial begin
    sVal[0]  = 32'h0000_0000; dVal[0]  = 64'h0000_0000_0000_0000; rank[0]  = 0; kind[0]  = 0;
    sVal[1]  = 32'h8000_0000; dVal[1]  = 64'h8000_0000_0000_0000; rank[1]  = 0; kind[1]  = 0;
    sVal[2]  = 32'h0000_0001; dVal[2]  = 64'h0000_0000_0000_0001; rank[2]  = 1; kind[2]  = 0;
    sVal[3]  = 32'h3F80_0000; dVal[3]  = 64'h3FF0_0000_0000_0000; rank[3]  = 2; kind[3]  = 0;
    sVal[4]  = 32'hBF80_0000; dVal[4]  = 64'hBFF0_0000_0000_0000; rank[4]  = 2; kind[4]  = 0;
    sVal[5]  = 32'h4000_0000; dVal[5]  = 64'h4000_0000_0000_0000; rank[5]  = 3; kind[5]  = 0;
    sVal[6]  = 32'hC040_0000; dVal[6]  = 64'hC008_0000_0000_0000; rank[6]  = 4; kind[6]  = 0;
    sVal[7]  = 32'h7F7F_FFFF; dVal[7]  = 64'h7FEF_FFFF_FFFF_FFFF; rank[7]  = 5; kind[7]  = 0;
    sVal[8]  = 32'h7F80_0000; dVal[8]  = 64'h7FF0_0000_0000_0000; rank[8]  = 6; kind[8]  = 0;
    sVal[9]  = 32'hFF80_0000; dVal[9]  = 64'hFFF0_0000_0000_0000; rank[9]  = 6; kind[9]  = 0;
    sVal[10] = 32'h7FC0_0000; dVal[10] = 64'h7FF8_0000_0000_0000; rank[10] = 0; kind[10] = 1;
    sVal[11] = 32'hFF80_0001; dVal[11] = 64'hFFF0_0000_0000_0001; rank[11] = 0; kind[11] = 2;

    repeat (3) @(negedge clk);
    chk("R1", ccReg, 8'h00);
    chk("R1", invalidFlag, 1'b0);
    chk("R1", oddIdxErr, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", ccReg, 8'h00);

    // single precision, every pair, every condition field
    for (int i = 0; i < 12; i++)
      for (int j = 0; j < 12; j++)
        for (int c = 0; c < 16; c++)
          doScalar(1'b0, i, j, 4'(c), 3'((i + j + c) % 8), 1'b0);

    // signed zeros (R11)
    doScalar(1'b0, 1, 0, 4'b0010, 3'd5, 1'b0);
    doScalar(1'b1, 0, 1, 4'b0010, 3'd6, 1'b0);

    // double precision
    for (int i = 0; i < 12; i++)
      for (int j = 0; j < 12; j++)
        for (int c = 0; c < 16; c += 5)
          doScalar(1'b1, i, j, 4'(c), 3'((i * 3 + j + c) % 8), 1'b0);

    // paired, even and odd indices
    for (int a = 0; a < 12; a++)
      for (int b = 0; b < 12; b++)
        for (int c = 0; c < 16; c += 3)
          doPaired(a, b, b, (a + 3) % 12, 4'(c), 3'((a + b + c) % 8));

    // trap enable suppresses the write on invalid (R9)
    for (int i = 0; i < 12; i++)
      for (int j = 0; j < 12; j++)
        doScalar(1'b0, i, j, 4'hF, 3'((i + 2 * j) % 8), 1'b1);

    // reserved format and idle cycles (R10)
    for (int k = 0; k < 8; k++) begin
      issue({32'h0, sVal[11]}, {32'h0, sVal[k]}, 2'd3, 4'hF, 3'(k), 1'b0);
      chk("R10", ccReg, ccExp);
      chk("R10", invalidFlag, 1'b0);
      chk("R10", oddIdxErr, 1'b0);
      opA = ~opA; opB = 64'h0;
      @(negedge clk);
      chk("R10", ccReg, ccExp);
      chk("R10", invalidFlag, 1'b0);
    end

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule